// File: doc/BRIEF.md
# Scroll-Wheel Event Decoder

This block sits behind a pointing-device packet decoder and turns its wheel field into two things a system can use directly. It watches the decoder's one-cycle event strobe together with the signed wheel delta carried in the same packet. For each wheel movement it accepts, it issues a one-cycle direction code. A zoom or list-scroll consumer can act on that code without any edge detection of its own.

Alongside the pulses, the block keeps a small thermometer gauge that climbs one bit per upward step and drops one bit per downward step. The gauge stops at both ends. A board can drive the gauge straight onto a row of LEDs as a visible wheel level.

Some wheels produce several strobes for one physical notch. An optional lockout window, measured in clock cycles, suppresses any further wheel events for a fixed time after each accepted one. A window length of zero turns the lockout off.

Top module: `scroll_wheel_decoder`

## Requirements
- R1: The `dir` output is 2'b10 for an upward step, 2'b01 for a downward step and 2'b00 when there is no step; 2'b11 never appears.
- R2: The direction code appears in the cycle after the clock edge at which the strobe was sampled. It stays non-idle for exactly that one cycle, unless the next edge also accepts an event.
- R3: `zpos` is read as two's complement. Any positive value (1 to 7) is an upward step. Any negative value (8 to 15, that is -8 to -1) is a downward step. The magnitude does not matter.
- R4: When `new_event` is low, `zpos` has no effect: no pulse appears and `gauge` holds.
- R5: A strobe whose delta is zero produces no pulse and leaves `gauge` unchanged.
- R6: From reset, successive upward steps move `gauge` through 0001, 0011, 0111 and 1111. Each step sets the lowest clear bit.
- R7: Successive downward steps move `gauge` from 1111 through 0111, 0011, 0001 and 0000. Each step clears the highest set bit.
- R8: At 1111 a further upward step, and at 0000 a further downward step, leave `gauge` unchanged but still produce the direction pulse.
- R9: With a lockout length L > 0, wheel events sampled on the L clock edges after an accepted event are ignored. The first nonzero event after that window is accepted.
- R10: With a lockout length of 0, wheel events on consecutive clock edges are each accepted.
- R11: When `rst` (synchronous, active high) is sampled high, `gauge` becomes 0000, `dir` becomes 2'b00 and any running lockout is cancelled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| new_event | input | 1 | One-cycle strobe marking a fresh decoded packet |
| zpos | input | DELTA_W (4) | Signed wheel delta of that packet |
| dir | output | 2 | Direction code: 10 up, 01 down, 00 idle |
| gauge | output | GAUGE_W (4) | Saturating thermometer wheel level |

## Verification
The bench builds two copies side by side from the same stimulus. One copy has a lockout length of 0, which makes back-to-back acceptance and every gauge step reachable in a few cycles. The other has a lockout length of 5, short enough that random strobes regularly land inside, at the edge of and just past the window. Resets are also issued while a window is still running. The default window of half a million cycles is left to the elaboration of the default parameters.

// File: rtl/scroll_wheel_pkg.sv
package scroll_wheel_pkg;

   // Direction code on the block's output; the bit positions are decoded downstream.
   typedef enum logic [1:0] {
      WHL_IDLE = 2'b00,
      WHL_DOWN = 2'b01,
      WHL_UP   = 2'b10
   } whl_dir_e;

endpackage

// File: rtl/wheel_sign_decode.sv
module wheel_sign_decode #(
   parameter int DELTA_W = 4
) (
   input  logic               valid,
   input  logic [DELTA_W-1:0] delta,
   output logic               want_up,
   output logic               want_down
);

   localparam int SIGN_BIT = DELTA_W - 1;

   logic moved;

   always_comb begin
      moved     = |delta;
      want_up   = valid && moved && !delta[SIGN_BIT];
      want_down = valid && delta[SIGN_BIT];
   end

endmodule

// File: rtl/wheel_lockout.sv
module wheel_lockout #(
   parameter int LOCKOUT_CYCLES = 500000
) (
   input  logic clk,
   input  logic rst,
   input  logic req,
   output logic grant
);

   localparam int CNT_W = (LOCKOUT_CYCLES > 0) ? $clog2(LOCKOUT_CYCLES + 1) : 1;

   generate
      if (LOCKOUT_CYCLES == 0) begin : g_pass
         logic unused_lk;
         assign unused_lk = &{1'b0, clk, rst};
         assign grant = req;
      end else begin : g_hold
         localparam logic [CNT_W-1:0] RELOAD = CNT_W'(LOCKOUT_CYCLES);
         logic [CNT_W-1:0] hold_cnt;

         assign grant = req && (hold_cnt == '0);

         always_ff @(posedge clk) begin
            if (rst) begin
               hold_cnt <= '0;
            end else if (grant) begin
               hold_cnt <= RELOAD;
            end else if (hold_cnt != '0) begin
               hold_cnt <= hold_cnt - CNT_W'(1);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/wheel_gauge.sv
module wheel_gauge
   import scroll_wheel_pkg::*;
#(
   parameter int GAUGE_W = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               step_up,
   input  logic               step_dn,
   output whl_dir_e           dir,
   output logic [GAUGE_W-1:0] level
);

   always_ff @(posedge clk) begin
      if (rst) begin
         level <= '0;
         dir   <= WHL_IDLE;
      end else if (step_up) begin
         level <= (level << 1) | GAUGE_W'(1);
         dir   <= WHL_UP;
      end else if (step_dn) begin
         level <= level >> 1;
         dir   <= WHL_DOWN;
      end else begin
         dir   <= WHL_IDLE;
      end
   end

endmodule

// File: rtl/scroll_wheel_decoder.sv
module scroll_wheel_decoder
   import scroll_wheel_pkg::*;
#(
   parameter int DELTA_W        = 4,
   parameter int GAUGE_W        = 4,
   parameter int LOCKOUT_CYCLES = 500000
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               new_event,
   input  logic [DELTA_W-1:0] zpos,
   output logic [1:0]         dir,
   output logic [GAUGE_W-1:0] gauge
);

   generate
      if (DELTA_W < 2) begin : g_bad_delta
         $error("scroll_wheel_decoder: DELTA_W must be at least 2");
      end
      if (GAUGE_W < 1) begin : g_bad_gauge
         $error("scroll_wheel_decoder: GAUGE_W must be at least 1");
      end
      if (LOCKOUT_CYCLES < 0) begin : g_bad_lock
         $error("scroll_wheel_decoder: LOCKOUT_CYCLES must not be negative");
      end
   endgenerate

   logic     want_up, want_down, grant;
   whl_dir_e dir_e;

   wheel_sign_decode #(.DELTA_W(DELTA_W)) u_sign (
      .valid     (new_event),
      .delta     (zpos),
      .want_up   (want_up),
      .want_down (want_down)
   );

   wheel_lockout #(.LOCKOUT_CYCLES(LOCKOUT_CYCLES)) u_lock (
      .clk   (clk),
      .rst   (rst),
      .req   (want_up | want_down),
      .grant (grant)
   );

   wheel_gauge #(.GAUGE_W(GAUGE_W)) u_gauge (
      .clk     (clk),
      .rst     (rst),
      .step_up (want_up & grant),
      .step_dn (want_down & grant),
      .dir     (dir_e),
      .level   (gauge)
   );

   assign dir = dir_e;

endmodule

// File: rtl/scroll_wheel_decoder_chk.sv
module scroll_wheel_decoder_chk #(
   parameter int DELTA_W        = 4,
   parameter int GAUGE_W        = 4,
   parameter int LOCKOUT_CYCLES = 500000
) (
   input logic               clk,
   input logic               rst,
   input logic               new_event,
   input logic [DELTA_W-1:0] zpos,
   input logic [1:0]         dir,
   input logic [GAUGE_W-1:0] gauge
);

   localparam int WIN_W = (LOCKOUT_CYCLES > 0) ? $clog2(LOCKOUT_CYCLES + 1) : 1;
   localparam logic [GAUGE_W-1:0] FULL = '1;

   logic             live;
   logic [WIN_W-1:0] win_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         live    <= 1'b0;
         win_cnt <= '0;
      end else begin
         live <= 1'b1;
         if (dir != 2'b00) begin
            win_cnt <= WIN_W'(LOCKOUT_CYCLES);
         end else if (win_cnt != '0) begin
            win_cnt <= win_cnt - WIN_W'(1);
         end
      end
   end

   AST_DIR_LEGAL: assert property (@(posedge clk) disable iff (rst)
      dir != 2'b11); // R1

   AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
      (live && dir != 2'b00) |-> ($past(new_event) && $past(zpos) != '0)); // R2

   AST_UP_SIGN: assert property (@(posedge clk) disable iff (rst)
      (live && dir == 2'b10) |-> !$past(zpos[DELTA_W-1])); // R3

   AST_DOWN_SIGN: assert property (@(posedge clk) disable iff (rst)
      (live && dir == 2'b01) |-> $past(zpos[DELTA_W-1])); // R3

   AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
      (live && dir == 2'b00) |-> $stable(gauge)); // R5

   AST_THERMO_SHAPE: assert property (@(posedge clk) disable iff (rst)
      (gauge & (gauge + GAUGE_W'(1))) == '0); // R6

   AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
      (live && dir == 2'b10 && $past(gauge) != FULL) |->
         $countones(gauge) == $countones($past(gauge)) + 1); // R6

   AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
      (live && dir == 2'b01 && $past(gauge) != '0) |->
         $countones(gauge) + 1 == $countones($past(gauge))); // R7

   AST_LOCK_WINDOW: assert property (@(posedge clk) disable iff (rst)
      (LOCKOUT_CYCLES > 0 && dir != 2'b00) |-> win_cnt == '0); // R9

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (gauge == '0 && dir == 2'b00)); // R11

endmodule

bind scroll_wheel_decoder scroll_wheel_decoder_chk #(
   .DELTA_W        (DELTA_W),
   .GAUGE_W        (GAUGE_W),
   .LOCKOUT_CYCLES (LOCKOUT_CYCLES)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .new_event (new_event),
   .zpos      (zpos),
   .dir       (dir),
   .gauge     (gauge)
);

// File: tb/test_scroll_wheel_decoder.sv
module test_scroll_wheel_decoder;

   localparam int LK = 5;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ev  = 1'b0;
   logic [3:0] z   = 4'h0;
   logic [1:0] dir_a, dir_b;
   logic [3:0] g_a, g_b;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [1:0] exp_dir_a = 2'b00, exp_dir_b = 2'b00;
   logic [3:0] exp_g_a = 4'h0, exp_g_b = 4'h0;
   int         lk_b = 0;

   always #10 clk = ~clk;

   scroll_wheel_decoder #(.DELTA_W(4), .GAUGE_W(4), .LOCKOUT_CYCLES(0)) i_scroll_wheel_decoder (
      .clk (clk), .rst (rst), .new_event (ev), .zpos (z), .dir (dir_a), .gauge (g_a)
   );

   scroll_wheel_decoder #(.DELTA_W(4), .GAUGE_W(4), .LOCKOUT_CYCLES(LK)) i_scroll_wheel_decoder_lk (
      .clk (clk), .rst (rst), .new_event (ev), .zpos (z), .dir (dir_b), .gauge (g_b)
   );

   function automatic logic [3:0] gauge_next(logic [3:0] g, logic up, logic dn);
      if (up) return {g[2:0], 1'b1};
      if (dn) return {1'b0, g[3:1]};
      return g;
   endfunction

   function automatic logic [1:0] dir_code(logic up, logic dn);
      return up ? 2'b10 : (dn ? 2'b01 : 2'b00);
   endfunction

   task automatic check(string tag, string what, logic [3:0] got, logic [3:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s got %b exp %b at %0t", tag, what, got, exp, $time);
      end
   endtask

   task automatic compare(string tag);
      check(tag, "A dir", {2'b00, dir_a}, {2'b00, exp_dir_a});
      check(tag, "A gauge", g_a, exp_g_a);
      check(tag, "B dir", {2'b00, dir_b}, {2'b00, exp_dir_b});
      check(tag, "B gauge", g_b, exp_g_b);
   endtask

   task automatic step(logic e, logic [3:0] zv, string tag);
      logic acc_a, acc_b, neg;
      ev = e;
      z  = zv;
      @(posedge clk);
      neg   = zv[3];
      acc_a = e && (zv != 4'h0);
      acc_b = acc_a && (lk_b == 0);
      lk_b  = acc_b ? LK : ((lk_b > 0) ? lk_b - 1 : 0);
      exp_dir_a = dir_code(acc_a && !neg, acc_a && neg);
      exp_g_a   = gauge_next(exp_g_a, acc_a && !neg, acc_a && neg);
      exp_dir_b = dir_code(acc_b && !neg, acc_b && neg);
      exp_g_b   = gauge_next(exp_g_b, acc_b && !neg, acc_b && neg);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic do_reset(logic e, logic [3:0] zv);
      rst = 1'b1;
      ev  = e;
      z   = zv;
      @(posedge clk);
      exp_dir_a = 2'b00; exp_dir_b = 2'b00;
      exp_g_a = 4'h0;    exp_g_b = 4'h0;
      lk_b = 0;
      @(negedge clk);
      compare("R11");
      rst = 1'b0;
   endtask

   task automatic idle(int n, string tag);
      for (int i = 0; i < n; i++) step(1'b0, 4'h0, tag);
   endtask

   initial begin
      void'($urandom(32'd20250409));
      @(negedge clk);
      do_reset(1'b0, 4'h0);
      do_reset(1'b1, 4'h3);

      // R6 fill from LSB, R8 saturation at top, R2 single-cycle pulse
      for (int i = 0; i < 5; i++) begin
         step(1'b1, 4'h1, (i < 4) ? "R6" : "R8");
         idle(LK + 1, "R2");
      end
      // R4 delta ignored without strobe
      step(1'b0, 4'h7, "R4");
      step(1'b0, 4'h9, "R4");
      // R5 zero-delta strobe
      step(1'b1, 4'h0, "R5");
      idle(1, "R5");
      // R7 down steps with -1 and -8, R3 magnitude irrelevant
      step(1'b1, 4'hF, "R7");
      idle(LK + 1, "R2");
      step(1'b1, 4'h8, "R3");
      idle(LK + 1, "R2");
      step(1'b1, 4'hC, "R7");
      idle(LK + 1, "R2");
      step(1'b1, 4'hF, "R7");
      idle(LK + 1, "R2");
      step(1'b1, 4'hF, "R8");
      idle(LK + 1, "R2");
      // R3 largest positive
      step(1'b1, 4'h7, "R3");
      // R10 back-to-back on the unlocked copy, R9 on the locked copy
      for (int i = 0; i < 8; i++) step(1'b1, (i % 2 == 0) ? 4'h2 : 4'h1, "R10");
      for (int i = 0; i < 3 * LK; i++) step(1'b1, 4'hE, "R9");
      idle(LK + 2, "R9");
      // R11 reset cancels a running lockout
      step(1'b1, 4'h1, "R9");
      do_reset(1'b0, 4'h0);
      step(1'b1, 4'h1, "R11");

      // R1 random mix
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(0, 299) == 0) begin
            do_reset(1'b0, 4'h0);
         end else begin
            step($urandom_range(0, 1) == 1, 4'($urandom_range(0, 15)), "R1");
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired got running exp finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule